// File: doc/BRIEF.md
# Stack and Interrupt-Vector Sequencer

This block performs the stack traffic for four control-flow operations of an 8-bit processor with a 16-bit program counter. The four operations are the software break, the return from interrupt, the subroutine call and the subroutine return. It also performs a standalone pull of the status register. It owns the program counter, the 8-bit stack pointer and the status register. It reaches memory through a plain synchronous port: address, write data and write enable go out, and read data comes back one clock after the address was presented.

A caller pulses `start` for one cycle with an operation code on `op_sel`. The sequencer then runs one memory access per cycle and reports completion with a single-cycle `done`. It ignores further starts until it has finished. The pin `brk_clears_dec` picks the processor variant, and it is latched at start. When it is high, a break also clears the decimal flag. Opcode fetch, hardware interrupts and arithmetic are handled elsewhere.

Top module: `stk_seq`

## Requirements
- R1: While reset is held, and after it is released, `pc_out` is 0x0000, `sp_out` is 0xFF and `status_out` is 0x34. `busy`, `done` and `mem_we` are all 0.
- R2: Every stack access uses address 0x0100 | SP. A push writes and then decrements SP. A pull increments SP and then reads. SP wraps modulo 256 in both directions, and no write ever leaves page 0x01.
- R3: Break (op 0) first adds 1 to PC. It then pushes PC high, then PC low, then the status byte with bits 5 and 4 forced to 1, so SP drops by 3.
- R4: After break, PC = {mem[0xFFFF], mem[0xFFFE]} and status bit 2 (interrupt disable) is 1.
- R5: With `brk_clears_dec` high at start, break clears status bit 3 (decimal). With it low, bit 3 keeps its value.
- R6: Return from interrupt (op 1) pulls the status byte with bits 5 and 4 forced to 1. It then pulls PC low and then PC high, so SP rises by 3.
- R7: Subroutine call (op 2) reads the target low byte at PC and adds 1 to PC. It pushes that PC high and then low, reads the target high byte at the new PC, and jumps to the target. SP drops by 2.
- R8: Subroutine return (op 3) pulls PC low and then PC high, and sets PC to that value plus 1 (0xFFFF becomes 0x0000). SP rises by 2.
- R9: Status pull (op 4) loads status from the stack with bits 5 and 4 forced to 1. SP rises by 1 and PC is unchanged.
- R10: `done` is high for exactly one cycle. Counting the start cycle as 0, it appears in cycle N+2, where N is the number of memory accesses (break 5, call 4, interrupt return 3, subroutine return 2, status pull 1). `busy` is high from cycle 1 until `done`.
- R11: A start while busy, or a start with op 5, 6 or 7, has no effect. It causes no memory write, no `done`, and no change to PC, SP or status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle request to begin an operation |
| op_sel | input | 3 | Operation code: 0 break, 1 interrupt return, 2 call, 3 return, 4 status pull |
| brk_clears_dec | input | 1 | Variant select: break also clears the decimal flag |
| mem_rdata | input | 8 | Read data, valid one cycle after its address |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| pc_out | output | 16 | Program counter |
| sp_out | output | 8 | Stack pointer (low byte; page fixed at 0x01) |
| status_out | output | 8 | Status register |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situations to reach from the ports are the stack pointer crossing the 0x00/0xFF boundary and a return whose pulled address is 0xFFFF. From reset, a status pull wraps SP to 0x00 so that the break that follows pushes across the boundary. The bench preloads its own memory model so that the return pulls 0xFFFF. A start issued while a break is running, and starts with unused codes, are driven directly. Several hundred seeded random operations then move SP around the whole page, against a reference model kept in bench functions.

// File: rtl/stk_seq_pkg.sv
package stk_seq_pkg;
  localparam int DW = 8;
  localparam int AW = 16;

  localparam logic [2:0] OP_BRK = 3'd0;
  localparam logic [2:0] OP_RTI = 3'd1;
  localparam logic [2:0] OP_JSR = 3'd2;
  localparam logic [2:0] OP_RTS = 3'd3;
  localparam logic [2:0] OP_PLP = 3'd4;

  localparam logic [DW-1:0] PS_I_MASK = 8'h04;
  localparam logic [DW-1:0] PS_D_MASK = 8'h08;
  localparam logic [DW-1:0] PS_FORCE  = 8'h30;

  typedef enum logic [3:0] {
    ST_IDLE, ST_B_PCH, ST_B_PCL, ST_B_PS, ST_B_VLO, ST_B_VHI,
    ST_J_LO, ST_J_PCH, ST_J_PCL, ST_J_HI,
    ST_PULL_PS, ST_PULL_LO, ST_PULL_HI, ST_FIN
  } st_e;

  typedef enum logic [2:0] {AS_PUSH, AS_PULL, AS_PC, AS_VLO, AS_VHI} asel_e;
  typedef enum logic [1:0] {WS_PCH, WS_PCL, WS_PS} wsel_e;

  typedef struct packed {
    asel_e asel;
    wsel_e wsel;
    logic  we;
    logic  sp_push;
    logic  sp_pull;
    logic  pc_inc;
    logic  tmp_ld;
    logic  ps_pull_ld;
    logic  ps_brk;
    logic  pc_ld;
    logic  pc_plus1;
  } ctl_t;
endpackage

// File: rtl/stk_seq_ctrl.sv
module stk_seq_ctrl
  import stk_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [2:0] op_i,
  input  logic       clr_dec_i,
  output ctl_t       ctl_o,
  output logic       busy_o,
  output logic       done_o,
  output logic [2:0] op_q_o,
  output logic       clr_dec_q_o
);
  st_e        st_q, st_d;
  logic [2:0] op_q;
  logic       clr_q;
  logic       done_q;
  logic       start_ok;

  assign start_ok = (st_q == ST_IDLE) && start_i && (op_i <= OP_PLP);

  always_comb begin
    ctl_o = '0;
    st_d  = st_q;
    case (st_q)
      ST_IDLE: begin
        if (start_ok) begin
          case (op_i)
            OP_BRK: begin st_d = ST_B_PCH; ctl_o.pc_inc = 1'b1; end
            OP_JSR: st_d = ST_J_LO;
            OP_RTS: st_d = ST_PULL_LO;
            default: st_d = ST_PULL_PS;
          endcase
        end
      end
      ST_B_PCH: begin
        ctl_o.asel = AS_PUSH; ctl_o.wsel = WS_PCH;
        ctl_o.we = 1'b1; ctl_o.sp_push = 1'b1;
        st_d = ST_B_PCL;
      end
      ST_B_PCL: begin
        ctl_o.asel = AS_PUSH; ctl_o.wsel = WS_PCL;
        ctl_o.we = 1'b1; ctl_o.sp_push = 1'b1;
        st_d = ST_B_PS;
      end
      ST_B_PS: begin
        ctl_o.asel = AS_PUSH; ctl_o.wsel = WS_PS;
        ctl_o.we = 1'b1; ctl_o.sp_push = 1'b1; ctl_o.ps_brk = 1'b1;
        st_d = ST_B_VLO;
      end
      ST_B_VLO: begin
        ctl_o.asel = AS_VLO;
        st_d = ST_B_VHI;
      end
      ST_B_VHI: begin
        ctl_o.asel = AS_VHI; ctl_o.tmp_ld = 1'b1;
        st_d = ST_FIN;
      end
      ST_J_LO: begin
        ctl_o.asel = AS_PC; ctl_o.pc_inc = 1'b1;
        st_d = ST_J_PCH;
      end
      ST_J_PCH: begin
        ctl_o.asel = AS_PUSH; ctl_o.wsel = WS_PCH;
        ctl_o.we = 1'b1; ctl_o.sp_push = 1'b1; ctl_o.tmp_ld = 1'b1;
        st_d = ST_J_PCL;
      end
      ST_J_PCL: begin
        ctl_o.asel = AS_PUSH; ctl_o.wsel = WS_PCL;
        ctl_o.we = 1'b1; ctl_o.sp_push = 1'b1;
        st_d = ST_J_HI;
      end
      ST_J_HI: begin
        ctl_o.asel = AS_PC;
        st_d = ST_FIN;
      end
      ST_PULL_PS: begin
        ctl_o.asel = AS_PULL; ctl_o.sp_pull = 1'b1;
        st_d = (op_q == OP_RTI) ? ST_PULL_LO : ST_FIN;
      end
      ST_PULL_LO: begin
        ctl_o.asel = AS_PULL; ctl_o.sp_pull = 1'b1;
        ctl_o.ps_pull_ld = (op_q == OP_RTI);
        st_d = ST_PULL_HI;
      end
      ST_PULL_HI: begin
        ctl_o.asel = AS_PULL; ctl_o.sp_pull = 1'b1; ctl_o.tmp_ld = 1'b1;
        st_d = ST_FIN;
      end
      ST_FIN: begin
        ctl_o.pc_ld      = (op_q != OP_PLP);
        ctl_o.pc_plus1   = (op_q == OP_RTS);
        ctl_o.ps_pull_ld = (op_q == OP_PLP);
        st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      op_q   <= OP_BRK;
      clr_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= (st_q == ST_FIN);
      if (start_ok) begin
        op_q  <= op_i;
        clr_q <= clr_dec_i;
      end
    end
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = done_q;
  assign op_q_o      = op_q;
  assign clr_dec_q_o = clr_q;

  // R11: the latched operation cannot change while a sequence runs
  a_r11_op_held: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |=> $stable(op_q));
endmodule

// File: rtl/stk_seq_sp.sv
module stk_seq_sp
  import stk_seq_pkg::*;
#(
  parameter logic [DW-1:0] STACK_PAGE = 8'h01,
  parameter logic [DW-1:0] SP_INIT    = 8'hFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pull_i,
  output logic [DW-1:0] sp_o,
  output logic [AW-1:0] push_addr_o,
  output logic [AW-1:0] pull_addr_o
);
  logic [DW-1:0] sp_q, sp_d, sp_up;

  assign sp_up = sp_q + 8'd1;

  always_comb begin
    sp_d = sp_q;
    if (push_i)      sp_d = sp_q - 8'd1;
    else if (pull_i) sp_d = sp_up;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= SP_INIT;
    else if (push_i || pull_i) sp_q <= sp_d;
  end

  assign sp_o        = sp_q;
  assign push_addr_o = {STACK_PAGE, sp_q};
  assign pull_addr_o = {STACK_PAGE, sp_up};

  // R2: the controller never asks for a push and a pull together
  a_r2_push_pull_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_i && pull_i));
endmodule

// File: rtl/stk_seq_regs.sv
module stk_seq_regs
  import stk_seq_pkg::*;
#(
  parameter logic [AW-1:0] PC_INIT = 16'h0000,
  parameter logic [DW-1:0] PS_INIT = 8'h34
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctl_t          ctl_i,
  input  logic          clr_dec_i,
  input  logic [DW-1:0] rdata_i,
  output logic [AW-1:0] pc_o,
  output logic [DW-1:0] ps_o,
  output logic [DW-1:0] wdata_o
);
  logic [AW-1:0] pc_q, pc_d;
  logic [DW-1:0] ps_q, ps_d;
  logic [DW-1:0] tmp_q;
  logic [DW-1:0] brk_clear;

  assign brk_clear = clr_dec_i ? PS_D_MASK : 8'h00;

  always_comb begin
    pc_d = pc_q;
    if (ctl_i.pc_inc)     pc_d = pc_q + 16'd1;
    else if (ctl_i.pc_ld) pc_d = {rdata_i, tmp_q} + {15'd0, ctl_i.pc_plus1};
  end

  always_comb begin
    ps_d = ps_q;
    if (ctl_i.ps_brk)          ps_d = (ps_q | PS_I_MASK) & ~brk_clear;
    else if (ctl_i.ps_pull_ld) ps_d = rdata_i | PS_FORCE;
  end

  always_comb begin
    case (ctl_i.wsel)
      WS_PCH:  wdata_o = pc_q[AW-1:DW];
      WS_PCL:  wdata_o = pc_q[DW-1:0];
      WS_PS:   wdata_o = ps_q | PS_FORCE;
      default: wdata_o = ps_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= PC_INIT;
      ps_q  <= PS_INIT;
      tmp_q <= '0;
    end else begin
      if (ctl_i.pc_inc || ctl_i.pc_ld)     pc_q  <= pc_d;
      if (ctl_i.ps_brk || ctl_i.ps_pull_ld) ps_q <= ps_d;
      if (ctl_i.tmp_ld)                    tmp_q <= rdata_i;
    end
  end

  assign pc_o = pc_q;
  assign ps_o = ps_q;
endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_seq_pkg::*;
#(
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [15:0] BRK_VEC    = 16'hFFFE,
  parameter logic [7:0]  SP_INIT    = 8'hFF,
  parameter logic [15:0] PC_INIT    = 16'h0000,
  parameter logic [7:0]  PS_INIT    = 8'h34
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [2:0]  op_sel,
  input  logic        brk_clears_dec,
  input  logic [7:0]  mem_rdata,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic        mem_we,
  output logic [15:0] pc_out,
  output logic [7:0]  sp_out,
  output logic [7:0]  status_out,
  output logic        busy,
  output logic        done
);
  localparam logic [AW-1:0] VEC_HI = BRK_VEC + 16'd1;

  logic [1:0]    rst_pipe;
  logic          rst_s;
  ctl_t          ctl;
  logic [2:0]    op_q;
  logic          clr_q;
  logic [AW-1:0] push_addr, pull_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  stk_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_s), .start_i(start), .op_i(op_sel),
    .clr_dec_i(brk_clears_dec), .ctl_o(ctl), .busy_o(busy), .done_o(done),
    .op_q_o(op_q), .clr_dec_q_o(clr_q)
  );

  stk_seq_sp #(.STACK_PAGE(STACK_PAGE), .SP_INIT(SP_INIT)) u_sp (
    .clk(clk), .rst_n(rst_s), .push_i(ctl.sp_push), .pull_i(ctl.sp_pull),
    .sp_o(sp_out), .push_addr_o(push_addr), .pull_addr_o(pull_addr)
  );

  stk_seq_regs #(.PC_INIT(PC_INIT), .PS_INIT(PS_INIT)) u_regs (
    .clk(clk), .rst_n(rst_s), .ctl_i(ctl), .clr_dec_i(clr_q),
    .rdata_i(mem_rdata), .pc_o(pc_out), .ps_o(status_out), .wdata_o(mem_wdata)
  );

  always_comb begin
    case (ctl.asel)
      AS_PUSH: mem_addr = push_addr;
      AS_PULL: mem_addr = pull_addr;
      AS_PC:   mem_addr = pc_out;
      AS_VLO:  mem_addr = BRK_VEC;
      AS_VHI:  mem_addr = VEC_HI;
      default: mem_addr = pc_out;
    endcase
  end
  assign mem_we = ctl.we;

  // R2: writes stay inside the stack page
  a_r2_write_in_page: assert property (@(posedge clk) disable iff (!rst_s)
    mem_we |-> (mem_addr[15:8] == STACK_PAGE));
  // R10: completion is a single-cycle pulse that ends a busy period
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_s)
    done |=> !done);
  a_r10_done_after_busy: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(done) |-> ($past(busy) && !busy));
  // R11: nothing is written while idle
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_s)
    !busy |-> !mem_we);
  // R4: interrupts are masked when a break completes
  a_r4_brk_masks: assert property (@(posedge clk) disable iff (!rst_s)
    (done && op_q == OP_BRK) |-> status_out[2]);
  // R6: forced status bits after any completed operation
  a_r6_status_forced: assert property (@(posedge clk) disable iff (!rst_s)
    done |-> (status_out[5:4] == 2'b11));
endmodule

// File: tb/stk_seq_tb.sv
module stk_seq_tb;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op_sel = 3'd0;
  logic        clr = 1'b0;
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic [15:0] pc_out;
  logic [7:0]  sp_out, status_out;
  logic        busy, done;

  int checks = 0;
  int errors = 0;

  logic [7:0]  stk  [256];
  logic [7:0]  mstk [256];
  logic [7:0]  vlo = 8'h00, vhi = 8'hC0;
  logic [15:0] m_pc;
  logic [7:0]  m_sp, m_ps;

  always #(CLK_NS/2) clk = ~clk;

  stk_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
    .brk_clears_dec(clr), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .pc_out(pc_out), .sp_out(sp_out),
    .status_out(status_out), .busy(busy), .done(done)
  );

  function automatic logic [7:0] prog_byte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5C;
  endfunction

  function automatic logic [7:0] bench_read(input logic [15:0] a);
    if (a[15:8] == 8'h01) return stk[a[7:0]];
    if (a == 16'hFFFE)    return vlo;
    if (a == 16'hFFFF)    return vhi;
    return prog_byte(a);
  endfunction

  function automatic logic [7:0] m_read(input logic [15:0] a);
    if (a[15:8] == 8'h01) return mstk[a[7:0]];
    if (a == 16'hFFFE)    return vlo;
    if (a == 16'hFFFF)    return vhi;
    return prog_byte(a);
  endfunction

  always @(posedge clk) begin
    if (mem_we && mem_addr[15:8] == 8'h01) stk[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= bench_read(mem_addr);
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic m_push(input logic [7:0] v);
    mstk[m_sp] = v;
    m_sp = m_sp - 8'd1;
  endtask

  task automatic m_pull(output logic [7:0] v);
    m_sp = m_sp + 8'd1;
    v = mstk[m_sp];
  endtask

  function automatic int exp_lat(input logic [2:0] o);
    case (o)
      3'd0: return 7;
      3'd1: return 5;
      3'd2: return 6;
      3'd3: return 4;
      default: return 3;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] o);
    case (o)
      3'd0: return "R3";
      3'd1: return "R6";
      3'd2: return "R7";
      3'd3: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic model_op(input logic [2:0] o, input logic c);
    logic [7:0] t, lo, hi;
    case (o)
      3'd0: begin
        m_pc = m_pc + 16'd1;
        m_push(m_pc[15:8]);
        m_push(m_pc[7:0]);
        m_push(m_ps | 8'h30);
        m_ps = m_ps | 8'h04;
        if (c) m_ps = m_ps & ~8'h08;
        m_pc = {vhi, vlo};
      end
      3'd1: begin
        m_pull(t); m_ps = t | 8'h30;
        m_pull(lo); m_pull(hi);
        m_pc = {hi, lo};
      end
      3'd2: begin
        lo = m_read(m_pc);
        m_pc = m_pc + 16'd1;
        m_push(m_pc[15:8]);
        m_push(m_pc[7:0]);
        hi = m_read(m_pc);
        m_pc = {hi, lo};
      end
      3'd3: begin
        m_pull(lo); m_pull(hi);
        m_pc = {hi, lo} + 16'd1;
      end
      default: begin
        m_pull(t); m_ps = t | 8'h30;
      end
    endcase
  endtask

  task automatic chk_state(input string req);
    int bad = 0;
    chk(pc_out == m_pc, req, "pc", pc_out, m_pc);
    chk(sp_out == m_sp, "R2", "sp", sp_out, m_sp);
    chk(status_out == m_ps, req, "status", status_out, m_ps);
    for (int i = 0; i < 256; i++) if (stk[i] !== mstk[i]) bad++;
    chk(bad == 0, req, "stack bytes differing", bad, 0);
  endtask

  task automatic run_op(input logic [2:0] o, input logic c);
    int lat;
    @(negedge clk); op_sel = o; clr = c; start = 1'b1;
    @(negedge clk); start = 1'b0; lat = 1;
    chk(busy == 1'b1, "R10", "busy after start", busy, 1);
    while (!done && lat < 30) begin @(negedge clk); lat++; end
    model_op(o, c);
    chk(lat == exp_lat(o), "R10", "done latency", lat, exp_lat(o));
    chk_state(req_of(o));
  endtask

  task automatic preload(input logic [7:0] a, input logic [7:0] v);
    stk[a] <= v;
    mstk[a] = v;
  endtask

  task automatic run_invalid(input logic [2:0] o);
    logic [15:0] p0; logic [7:0] s0, f0; int ev = 0;
    p0 = pc_out; s0 = sp_out; f0 = status_out;
    @(negedge clk); op_sel = o; start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (done || mem_we || busy) ev++;
      @(negedge clk);
    end
    chk(ev == 0, "R11", "activity on unused op", ev, 0);
    chk(pc_out == p0 && sp_out == s0 && status_out == f0, "R11",
        "state after unused op", {pc_out, sp_out, status_out}, {p0, s0, f0});
  endtask

  task automatic run_busy_start;
    int lat, dones = 0;
    @(negedge clk); op_sel = 3'd0; clr = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0; lat = 1;
    @(negedge clk); op_sel = 3'd3; start = 1'b1; lat++;
    @(negedge clk); start = 1'b0; lat++;
    while (!done && lat < 30) begin @(negedge clk); lat++; end
    for (int i = 0; i < 10; i++) begin
      if (done) dones++;
      @(negedge clk);
    end
    model_op(3'd0, 1'b0);
    chk(lat == 7, "R11", "latency with start while busy", lat, 7);
    chk(dones == 1, "R11", "done pulses", dones, 1);
    chk_state("R11");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      stk[i] <= 8'(i * 7 + 3);
      mstk[i] = 8'(i * 7 + 3);
    end
    m_pc = 16'h0000; m_sp = 8'hFF; m_ps = 8'h34;
    repeat (4) @(negedge clk);
    chk(pc_out == 16'h0000 && sp_out == 8'hFF && status_out == 8'h34, "R1",
        "state in reset", {pc_out, sp_out, status_out}, 32'h0000FF34);
    chk(!busy && !done && !mem_we, "R1", "flags in reset",
        {busy, done, mem_we}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(pc_out == 16'h0000 && sp_out == 8'hFF && status_out == 8'h34, "R1",
        "state after release", {pc_out, sp_out, status_out}, 32'h0000FF34);

    // R2 wrap on pull: SP FF -> 00, reads 0x0100
    preload(8'h00, 8'h08);
    run_op(3'd4, 1'b0);
    chk(sp_out == 8'h00, "R2", "pull wrap sp", sp_out, 8'h00);
    chk(status_out == 8'h38, "R9", "pulled status", status_out, 8'h38);

    // R2 wrap on push, R5 decimal kept with variant low
    vlo = 8'h21; vhi = 8'h43;
    run_op(3'd0, 1'b0);
    chk(sp_out == 8'hFD, "R2", "push wrap sp", sp_out, 8'hFD);
    chk(status_out[3] == 1'b1, "R5", "decimal kept", status_out[3], 1);
    chk(pc_out == 16'h4321, "R4", "vector pc", pc_out, 16'h4321);

    // R8 return from 0xFFFF wraps to 0x0000
    preload(8'hFE, 8'hFF); preload(8'hFF, 8'hFF);
    run_op(3'd3, 1'b0);
    chk(pc_out == 16'h0000, "R8", "return wrap", pc_out, 16'h0000);

    // R6 interrupt return
    preload(8'h00, 8'hCF); preload(8'h01, 8'h34); preload(8'h02, 8'h12);
    run_op(3'd1, 1'b0);
    chk(pc_out == 16'h1234 && status_out == 8'hFF, "R6", "rti result",
        {pc_out, status_out}, 24'h1234FF);

    // R7 call, R5 decimal cleared with variant high
    run_op(3'd2, 1'b0);
    vlo = 8'h00; vhi = 8'h80;
    run_op(3'd0, 1'b1);
    chk(status_out[3] == 1'b0, "R5", "decimal cleared", status_out[3], 0);

    // R11 cases
    run_busy_start();
    run_invalid(3'd5);
    run_invalid(3'd7);

    void'($urandom(32'd20240611));
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 15) == 0) begin
        run_invalid(3'($urandom_range(5, 7)));
      end else begin
        logic [2:0] o;
        o = 3'($urandom_range(0, 4));
        vlo = 8'($urandom); vhi = 8'($urandom);
        run_op(o, 1'($urandom_range(0, 1)));
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule